// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the front-end control for a pipelined synchronous burst SRAM. Its words are two lanes wide, and each lane is nine bits: eight data bits plus one parity bit. At every rising clock edge the controller decides whether a new access begins. It makes that decision from two address strobes and three chip enables:

- a processor-side strobe, `procStrobeN`;
- a controller-side strobe, `ctrlStrobeN`.

It also decodes the per-lane write enables from a global write, a byte-write enable and per-lane selects. While a burst is open, an advance input steps the burst counter, which is two bits wide and wraps within an aligned group of four words. The burst order is either linear or interleaved, as chosen by a static input.

Read data is registered. Data for the address of one edge appears on the data output after the following edge. The output drive is gated by an asynchronous active-low output enable. Because of the pipeline, no drive appears in the first cycle of a read that starts from a deselected state. A behavioural memory array, whose depth follows the address width, sits behind the controller so that the whole path can be checked.

The write data and the read data use separate ports. `rdDrive` tells the pad ring when to drive the shared bus.

Top module: `burst_sram_front`

## Requirements
- R1: After reset `rdDrive` and `rdData` are 0. A new access starts only at an edge where an address strobe is accepted and `ce1N`=0, `ce2`=1, `ce3N`=0 hold. The address is captured then, and the burst count restarts at 0.
- R2: `procStrobeN` low is ignored while `ce1N` is high. An open burst then continues as if no strobe were present. When both strobes are low and `ce1N` is low, the processor strobe is the one taken.
- R3: The chip enables matter only at an edge where a strobe is accepted. Changing them in other cycles does not disturb an open burst.
- R4: `globalWrN` low makes the access a write of both lanes, whatever `byteWrEnN` and `byteSelN` are.
- R5: With `globalWrN` high and `byteWrEnN` low, lane i is written only if `byteSelN[i]` is low. Lane 0 is `wrData[8:0]` and lane 1 is `wrData[17:9]`. If no lane is enabled, the access is a read.
- R6: Read data for the word addressed at edge k is on `rdData` after edge k+1.
- R7: With `burstLinear`=1, offset n of a burst addresses low bits (start+n) mod 4. The upper address bits stay fixed.
- R8: With `burstLinear`=0, offset n addresses low bits start XOR n.
- R9: With no strobe accepted and `advN` high, an open burst repeats its current address.
- R10: With no strobe accepted and `advN` low, an open burst moves to its next offset and keeps its read or write type. A write step uses the lanes enabled in that cycle.
- R11: `rdDrive` = !`outEnN` AND (a read was addressed two edges earlier). This is asynchronous in `outEnN`. As a result there is no drive in the first cycle after a read starts from deselect.
- R12: A strobe accepted while not selected closes the burst. No further accesses occur, and `rdDrive` is low from the second edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Word address, captured when an access starts |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| ce1N | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| advN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write-all-lanes request, active low |
| byteWrEnN | input | 1 | Byte-write qualifier, active low |
| byteSelN | input | 2 | Per-lane write selects, active low |
| burstLinear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| wrData | input | 18 | Write data, sampled with the access |
| rdData | output | 18 | Registered read data |
| rdDrive | output | 1 | Bus drive request for the read data |

## Verification
The bench starts with global-write bursts that fill every address while the byte selects are held inactive. This shows that global write overrides the lane selects. Read bursts are then run from start offsets that are not zero, in both burst orders, so a wrong wrap or a swapped order yields a different address. Lane-selective writes, and a byte-write enable with no selected lane, separate a partial write from a misread read cycle. Strobes with `ce1N` high, both strobes together, enable changes mid-burst, advance holds and a long mixed random stream then separate strobe arbitration, deselect and continuation errors in a cycle-exact model.

// File: rtl/sram_front_pkg.sv
package sram_front_pkg;
  localparam int ADDR_W  = 8;
  localparam int LANES   = 2;
  localparam int LANE_W  = 9;
  localparam int BURST_W = 2;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int DEPTH   = 1 << ADDR_W;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [LANES-1:0]  laneMask;
    logic [ADDR_W-1:0] accAddr;
  } ctrl_strobe_t;
endpackage

// File: rtl/sram_front_ctrl.sv
module sram_front_ctrl
  import sram_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  byteSelN,
  input  logic              burstLinear,
  output ctrl_strobe_t      strobes
);
  logic              activeQ, writeQ;
  logic [ADDR_W-1:0] baseQ;
  logic [BURST_W-1:0] cntQ;

  logic              activeD, writeD;
  logic [ADDR_W-1:0] baseD;
  logic [BURST_W-1:0] cntD;
  logic [BURST_W-1:0] lowBits;
  logic              procTake, ctrlTake, startAcc, chipSel, accessNow;
  logic [LANES-1:0]  laneMask;

  always_comb begin
    // processor strobe wins, but only when the first enable is active
    procTake = !procStrobeN && !ce1N;
    ctrlTake = !ctrlStrobeN && !procTake;
    startAcc = procTake || ctrlTake;
    chipSel  = !ce1N && ce2 && !ce3N;

    if (!globalWrN)      laneMask = '1;
    else if (!byteWrEnN) laneMask = ~byteSelN;
    else                 laneMask = '0;

    activeD   = activeQ;
    writeD    = writeQ;
    baseD     = baseQ;
    cntD      = cntQ;
    accessNow = 1'b0;

    if (startAcc) begin
      if (chipSel) begin
        activeD   = 1'b1;
        writeD    = |laneMask;
        baseD     = addr;
        cntD      = '0;
        accessNow = 1'b1;
      end else begin
        activeD   = 1'b0;
      end
    end else if (activeQ) begin
      accessNow = 1'b1;
      if (!advN) cntD = cntQ + 1'b1;
    end

    if (burstLinear) lowBits = baseD[BURST_W-1:0] + cntD;
    else             lowBits = baseD[BURST_W-1:0] ^ cntD;

    strobes.accAddr  = {baseD[ADDR_W-1:BURST_W], lowBits};
    strobes.laneMask = laneMask;
    strobes.wrEn     = accessNow && writeD && (|laneMask);
    strobes.rdEn     = accessNow && !writeD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      writeQ  <= 1'b0;
      baseQ   <= '0;
      cntQ    <= '0;
    end else begin
      activeQ <= activeD;
      writeQ  <= writeD;
      baseQ   <= baseD;
      cntQ    <= cntD;
    end
  end

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ce1N && ce2 && !ce3N) |=> (baseQ == $past(addr)) && (cntQ == '0)); // R1
  AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !procStrobeN && ce1N && ctrlStrobeN) |=> activeQ); // R2
  AST_ADV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && procStrobeN && ctrlStrobeN && advN) |=> ($stable(cntQ) && $stable(baseQ))); // R9
  AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && ce1N) |=> !activeQ); // R12
endmodule

// File: rtl/sram_front_data.sv
module sram_front_data
  import sram_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEnN,
  input  logic              globalWrN,
  input  logic [LANES-1:0]  byteSelN,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);
  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdPendQ, readPipeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddrQ   <= '0;
      rdPendQ   <= 1'b0;
      readPipeQ <= 1'b0;
    end else begin
      rdAddrQ   <= strobes.accAddr;
      rdPendQ   <= strobes.rdEn;
      readPipeQ <= rdPendQ;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.laneMask[g])
        laneMem[strobes.accAddr] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        laneQ <= '0;
      else if (rdPendQ) laneQ <= laneMem[rdAddrQ];
    end

    assign rdData[g*LANE_W +: LANE_W] = laneQ;
  end

  assign rdDrive = !outEnN && readPipeQ;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> ##1 readPipeQ); // R6
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> ##1 !rdDrive); // R12
  AST_LANE_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && globalWrN) |-> ((strobes.laneMask & byteSelN) == '0)); // R5
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
  import sram_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  byteSelN,
  input  logic              burstLinear,
  input  logic              outEnN,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);
  ctrl_strobe_t strobes;

  sram_front_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .ce1N        (ce1N),
    .ce2         (ce2),
    .ce3N        (ce3N),
    .advN        (advN),
    .globalWrN   (globalWrN),
    .byteWrEnN   (byteWrEnN),
    .byteSelN    (byteSelN),
    .burstLinear (burstLinear),
    .strobes     (strobes)
  );

  sram_front_data i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .outEnN    (outEnN),
    .globalWrN (globalWrN),
    .byteSelN  (byteSelN),
    .rdData    (rdData),
    .rdDrive   (rdDrive)
  );
endmodule

// File: tb/test_burst_sram_front.sv
`timescale 1ns/1ps
module test_burst_sram_front;
  import sram_front_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic              procStrobeN, ctrlStrobeN, ce1N, ce2, ce3N, advN;
  logic              globalWrN, byteWrEnN, burstLinear, outEnN;
  logic [LANES-1:0]  byteSelN;
  logic [WORD_W-1:0] wrData;
  logic [WORD_W-1:0] rdData;
  logic              rdDrive;

  burst_sram_front i_burst_sram_front (
    .clk(clk), .rstN(rstN), .addr(addr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advN(advN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .byteSelN(byteSelN), .burstLinear(burstLinear), .outEnN(outEnN),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;
  string phaseTag = "R1 reset";

  // behavioural reference state
  logic [WORD_W-1:0] mMem [DEPTH];
  bit                mActive, mWrite, mPend, mPipe;
  int                mBase, mCnt, mPendAddr;
  logic [WORD_W-1:0] mData;

  function automatic logic [WORD_W-1:0] pattern(int a);
    return WORD_W'((a * 1237 + 341) ^ (a << 10));
  endfunction

  function automatic int burstAddr(int base, int cnt, bit lin);
    int lo = base % 4;
    int off = lin ? ((lo + cnt) % 4) : (lo ^ cnt);
    return base - lo + off;
  endfunction

  task automatic check(bit ok, string what, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phaseTag, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit pT, cT, start, sel, acc;
    logic [LANES-1:0] mask;
    int a;
    if (mPend) mData = mMem[mPendAddr];
    mPipe = mPend;
    pT = (procStrobeN == 0) && (ce1N == 0);
    cT = (ctrlStrobeN == 0) && !pT;
    start = pT || cT;
    sel = (ce1N == 0) && (ce2 == 1) && (ce3N == 0);
    mask = '0;
    if (globalWrN == 0) mask = '1;
    else if (byteWrEnN == 0) mask = ~byteSelN;
    acc = 0;
    if (start) begin
      if (sel) begin
        mActive = 1; mBase = int'(addr); mCnt = 0; mWrite = (mask != 0); acc = 1;
      end else mActive = 0;
    end else if (mActive) begin
      if (advN == 0) mCnt = (mCnt + 1) % 4;
      acc = 1;
    end
    mPend = 0;
    if (acc) begin
      a = burstAddr(mBase, mCnt, burstLinear);
      if (mWrite) begin
        for (int l = 0; l < LANES; l++)
          if (mask[l]) mMem[a][l*LANE_W +: LANE_W] = wrData[l*LANE_W +: LANE_W];
      end else begin
        mPend = 1; mPendAddr = a;
      end
    end
  endtask

  task automatic compareNow();
    bit expDrive = (outEnN == 0) && mPipe;
    check(rdDrive == expDrive, "drive", WORD_W'(rdDrive), WORD_W'(expDrive));
    if (expDrive) check(rdData == mData, "data", rdData, mData);
  endtask

  // inputs are set at a falling edge, then one clock is taken
  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareNow();
  endtask

  task automatic setIdle();
    procStrobeN = 1; ctrlStrobeN = 1; advN = 1;
    globalWrN = 1; byteWrEnN = 1; byteSelN = '1;
    ce1N = 0; ce2 = 1; ce3N = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; setIdle(); addr = '0; wrData = '0; burstLinear = 1; outEnN = 0;
    mActive = 0; mWrite = 0; mPend = 0; mPipe = 0; mBase = 0; mCnt = 0; mPendAddr = 0; mData = '0;
    repeat (3) @(negedge clk);
    // R1: reset state even with output enable active
    check(rdDrive == 0, "R1 reset drive", WORD_W'(rdDrive), '0);
    check(rdData == '0, "R1 reset data", rdData, '0);
    rstN = 1;

    // fill memory: global write with lane selects inactive, bursts of four
    phaseTag = "R4 R10 global fill";
    for (int b = 0; b < DEPTH / 4; b++) begin
      setIdle(); procStrobeN = 0; addr = ADDR_W'(b * 4);
      globalWrN = 0; byteSelN = '1; wrData = pattern(b * 4);
      tick();
      procStrobeN = 1; advN = 0;
      for (int k = 1; k < 4; k++) begin
        wrData = pattern(b * 4 + k);
        tick();
      end
    end

    // linear read burst from offset 2
    phaseTag = "R6 R7 R11 linear read";
    setIdle(); burstLinear = 1; ctrlStrobeN = 0; addr = 8'h12;
    tick();
    ctrlStrobeN = 1; advN = 0;
    tick();
    check(rdDrive && rdData == pattern(8'h12), "R6 first word", rdData, pattern(8'h12));
    tick();
    check(rdData == pattern(8'h13), "R7 second word", rdData, pattern(8'h13));
    tick();
    check(rdData == pattern(8'h10), "R7 wrap word", rdData, pattern(8'h10));
    // R11: output enable acts without a clock
    outEnN = 1; #1;
    check(rdDrive == 0, "R11 oe high", WORD_W'(rdDrive), '0);
    outEnN = 0; #1;
    check(rdDrive == 1, "R11 oe low", WORD_W'(rdDrive), 1);
    tick(); tick();

    // interleaved read burst from offset 3
    phaseTag = "R8 interleaved read";
    setIdle(); burstLinear = 0; procStrobeN = 0; addr = 8'h27;
    tick();
    procStrobeN = 1; advN = 0;
    tick();
    check(rdData == pattern(8'h27), "R8 first word", rdData, pattern(8'h27));
    tick();
    check(rdData == pattern(8'h26), "R8 second word", rdData, pattern(8'h26));
    tick();
    check(rdData == pattern(8'h25), "R8 third word", rdData, pattern(8'h25));
    burstLinear = 1;

    // lane writes: lane 0 only, then byte enable with no lane = read
    phaseTag = "R5 lane write";
    setIdle(); ctrlStrobeN = 0; addr = 8'h40; byteWrEnN = 0; byteSelN = 2'b10;
    wrData = 18'h3_ffff;
    tick();
    setIdle(); ctrlStrobeN = 0; addr = 8'h41; byteWrEnN = 0; byteSelN = 2'b11;
    wrData = 18'h0_0000;
    tick();
    setIdle(); ctrlStrobeN = 0; addr = 8'h40;
    tick(); tick(); tick();

    // advance held
    phaseTag = "R9 hold";
    setIdle(); procStrobeN = 0; addr = 8'h55;
    tick();
    procStrobeN = 1;
    repeat (3) tick();
    advN = 0; tick(); advN = 1; tick(); tick();

    // processor strobe with ce1N high is ignored; burst goes on
    phaseTag = "R2 ignored strobe";
    procStrobeN = 0; ce1N = 1; advN = 0;
    repeat (3) tick();
    // both strobes low with selection
    setIdle(); procStrobeN = 0; ctrlStrobeN = 0; addr = 8'h81;
    tick();
    setIdle(); advN = 0; tick(); tick();

    // enables changed mid-burst do nothing
    phaseTag = "R3 enables mid burst";
    ce2 = 0; ce3N = 1; tick(); ce1N = 1; tick();
    setIdle(); advN = 0; tick(); tick();

    // deselect through controller strobe, then idle
    phaseTag = "R12 deselect";
    setIdle(); ctrlStrobeN = 0; ce2 = 0;
    tick();
    setIdle(); advN = 0;
    repeat (4) tick();
    // read from deselected state: first cycle not driven
    phaseTag = "R11 first read after deselect";
    ctrlStrobeN = 0; addr = 8'h9c;
    tick();
    check(rdDrive == 0, "R11 first cycle masked", WORD_W'(rdDrive), '0);
    ctrlStrobeN = 1;
    tick(); tick();

    // mixed stream
    phaseTag = "R1 R2 R3 R5 R10 R12 mixed";
    for (int i = 0; i < 2000; i++) begin
      procStrobeN = ($urandom_range(0, 5) != 0);
      ctrlStrobeN = ($urandom_range(0, 5) != 0);
      ce1N        = ($urandom_range(0, 7) == 0);
      ce2         = ($urandom_range(0, 7) != 0);
      ce3N        = ($urandom_range(0, 7) == 0);
      advN        = ($urandom_range(0, 3) == 0);
      globalWrN   = ($urandom_range(0, 4) != 0);
      byteWrEnN   = ($urandom_range(0, 2) == 0);
      byteSelN    = LANES'($urandom_range(0, 3));
      burstLinear = ($urandom_range(0, 1) == 1);
      outEnN      = ($urandom_range(0, 5) == 0);
      addr        = ADDR_W'($urandom_range(0, DEPTH - 1));
      wrData      = WORD_W'($urandom);
      tick();
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule